// File: doc/BRIEF.md
# Fast Interrupt Manager with Source Redirection

This block drives the active-low fast interrupt request line of a processor core. The request comes from the dedicated fast source (source 0) or from any normal source that software has redirected onto the fast path. A per-source redirect status is kept here. Software sets it through a write-one set command and clears it through a write-one clear command. Redirected sources are removed from the visibility vector handed to the priority arbiter, so they can never raise the normal request.

The block takes the pending and enabled vectors from the source conditioning logic, plus the normal request from the external arbiter. It drives the fast, normal and combined request lines, all registered. It also serves a small register port holding these registers: the fast handler address of source 0, a spurious vector, a debug control bit, a fast vector read port and a core line status word. When no redirect is active, a fast vector read of an edge-triggered source 0 emits a one-cycle clear pulse back to the conditioning logic. Redirected edge sources are left for the explicit clear command of the conditioning logic.

Top module: `fast_irq_manager`

## Requirements
- R1: The redirect status resets to 0. A write to address 1 (set) sets each status bit whose data bit is 1, and a write to address 2 (clear) clears each status bit whose data bit is 1. Zero data bits change nothing. Bit 0 (the fast source) can never be set. The status reads back at address 3, right-aligned.
- R2: The arbitration visibility output equals pending AND enabled for sources 1 and up, with every redirected source and source 0 forced to 0.
- R3: One cycle after source 0 is pending and enabled, or any redirected source is pending and enabled, `fiq_n` is low. Otherwise it is high one cycle later. This holds as well when a redirected level source drops its pending bit. An unredirected normal source never drives `fiq_n`.
- R4: A read of address 4 (fast vector) while the registered fast request is active returns the source-0 handler address (address 5, read/write), whichever source raised the request.
- R5: A read of address 4 while the registered fast request is inactive returns the spurious vector (address 6, read/write).
- R6: `src0_clr` pulses in the cycle of a non-spurious fast vector read only if source 0 is edge-triggered (`src0_edge`=1) and no redirect status bit is set.
- R7: With debug control bit 0 (address 7) set, `fiq_n` and `irq_n` are held high one cycle later, while `int_n` still follows the requests.
- R8: `int_n` is low one cycle after either the fast request or `norm_req` is active, and high otherwise.
- R9: A read of address 0 (core status) returns bit 0 = fast line active (`fiq_n` low) and bit 1 = normal line active (`irq_n` low).
- R10: After reset all three request outputs are high, and the stored vectors, debug bit and core status read 0.
- R11: With the debug bit clear, `irq_n` is low one cycle after `norm_req` is high, and high one cycle after it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| src_pend | input | NUM_SRC | Pending vector from source conditioning |
| src_en | input | NUM_SRC | Enabled vector from source conditioning |
| src0_edge | input | 1 | Source 0 is programmed edge-triggered |
| norm_req | input | 1 | Normal request from the priority arbiter |
| arb_vis | output | NUM_SRC | Sources visible to priority arbitration |
| src0_clr | output | 1 | Clear pulse for edge-triggered source 0 |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |
| int_n | output | 1 | Combined interrupt, active low |

## Verification
The fast line is driven in turn by source 0 alone, by a redirected edge source, by a redirected level source that later drops, and by an unredirected normal source. This separates the redirect gating from the source-0 path. Fast vector reads are made with a redirected source active, with no request at all, and with source 0 active under both edge and level settings. These reads distinguish the vector, spurious and clear-pulse decisions. Debug masking is applied while both requests are active, to show that only the two core lines are gated and the combined line is not.

// File: rtl/fim_pkg.sv
// Package: shared register addresses for the fast interrupt manager.
// Assumes a word-addressed 3-bit register port.
package fim_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CORE_STAT  = 3'd0,
        A_REDIR_SET  = 3'd1,
        A_REDIR_CLR  = 3'd2,
        A_REDIR_STAT = 3'd3,
        A_FAST_VEC   = 3'd4,
        A_VEC0       = 3'd5,
        A_SPUR_VEC   = 3'd6,
        A_DBG_CTRL   = 3'd7
    } fim_addr_e;
endpackage

// File: rtl/fim_redirect_reg.sv
// Module: per-source redirect status bits with write-one set and clear.
// Assumes set and clear strobes never occur in the same cycle (one address per access).
// Source 0 is the dedicated fast source and carries no redirect bit.
module fim_redirect_reg #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] redir
);
    localparam logic [NUM_SRC-1:0] SETTABLE = {{(NUM_SRC-1){1'b1}}, 1'b0};

    logic [NUM_SRC-1:0] set_bits;
    assign set_bits = wbits & SETTABLE;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i == 0) begin : g_fast
            // Source 0 never redirects.
            assign redir[i] = 1'b0;
        end else begin : g_norm
            logic bit_q;
            // Status bit: set by a one on set, cleared by a one on clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (set_stb && wbits[i])
                    bit_q <= 1'b1;
                else if (clr_stb && wbits[i])
                    bit_q <= 1'b0;
            end
            assign redir[i] = bit_q;
        end
    end

    AST_REDIR_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((redir & $past(set_bits)) == $past(set_bits))); // R1

    AST_REDIR_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((redir & $past(wbits)) == '0)); // R1

    AST_REDIR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(redir)); // R1
endmodule

// File: rtl/fim_request.sv
// Module: forms the fast request, the arbitration visibility vector and the
// three registered active-low request lines.
// Assumes pending/enabled come from conditioning logic that already applies
// edge or level detection, so a level source drops its pending bit itself.
module fim_request #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] redir,
    input  logic               norm_req,
    input  logic               dbg_mask,
    output logic [NUM_SRC-1:0] arb_vis,
    output logic               fast_act,
    output logic               fiq_n,
    output logic               irq_n,
    output logic               int_n
);
    localparam logic [NUM_SRC-1:0] NORMAL_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

    logic [NUM_SRC-1:0] live;
    logic               fast_c;

    // Live sources and the fast request term.
    always_comb begin
        live    = pend & en;
        fast_c  = live[0] | (|(live & redir & NORMAL_MASK));
        arb_vis = live & ~redir & NORMAL_MASK;
    end

    // Registered request lines; debug gates only the two core lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_act <= 1'b0;
            fiq_n    <= 1'b1;
            irq_n    <= 1'b1;
            int_n    <= 1'b1;
        end else begin
            fast_act <= fast_c;
            fiq_n    <= ~(fast_c & ~dbg_mask);
            irq_n    <= ~(norm_req & ~dbg_mask);
            int_n    <= ~(fast_c | norm_req);
        end
    end

    AST_FIQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_n |-> fast_act); // R3

    AST_FIQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_c |=> fiq_n); // R3

    AST_DBG_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mask |=> (fiq_n && irq_n)); // R7

    AST_INT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_c || norm_req) |=> !int_n); // R8

    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_req && !dbg_mask) |=> !irq_n); // R11
endmodule

// File: rtl/fim_regs.sv
// Module: register port of the fast interrupt manager. Holds the source-0
// handler address, spurious vector and debug bit, decodes command strobes,
// returns read data and raises the source-0 clear pulse.
// Assumes read and write strobes are not both high in the same cycle.
module fim_regs
    import fim_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] redir,
    input  logic               fast_act,
    input  logic               src0_edge,
    input  logic               fiq_n,
    input  logic               irq_n,
    output logic               set_stb,
    output logic               clr_stb,
    output logic               dbg_mask,
    output logic [DATA_W-1:0]  rdata,
    output logic               src0_clr
);
    fim_addr_e          a;
    logic [DATA_W-1:0]  vec0_q;
    logic [DATA_W-1:0]  spur_q;
    logic               dbg_q;
    logic               fvec_rd;

    assign a        = fim_addr_e'(addr);
    assign dbg_mask = dbg_q;

    // Command strobes towards the redirect status.
    always_comb begin
        set_stb = wr && (a == A_REDIR_SET);
        clr_stb = wr && (a == A_REDIR_CLR);
        fvec_rd = rd && (a == A_FAST_VEC);
    end

    // Stored read/write registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec0_q <= '0;
            spur_q <= '0;
            dbg_q  <= 1'b0;
        end else if (wr) begin
            case (a)
                A_VEC0:     vec0_q <= wdata;
                A_SPUR_VEC: spur_q <= wdata;
                A_DBG_CTRL: dbg_q  <= wdata[0];
                default:    ;
            endcase
        end
    end

    // Read data multiplexer, zero outside a read.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (a)
                A_CORE_STAT:  begin
                    rdata[0] = ~fiq_n;
                    rdata[1] = ~irq_n;
                end
                A_REDIR_STAT: rdata[NUM_SRC-1:0] = redir;
                A_FAST_VEC:   rdata = fast_act ? vec0_q : spur_q;
                A_VEC0:       rdata = vec0_q;
                A_SPUR_VEC:   rdata = spur_q;
                A_DBG_CTRL:   rdata[0] = dbg_q;
                default:      rdata = '0;
            endcase
        end
    end

    // Clear pulse for an edge-triggered source 0 on a true fast vector read.
    assign src0_clr = fvec_rd && fast_act && src0_edge && (redir == '0);

    AST_SPUR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fvec_rd && !fast_act) |-> (rdata == spur_q)); // R5

    AST_CLR_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        src0_clr |-> (rdata == vec0_q)); // R6
endmodule

// File: rtl/fast_irq_manager.sv
// Module: top of the fast interrupt manager. Connects the redirect status,
// request forming and register port.
// Assumes DATA_W is at least NUM_SRC and NUM_SRC is at least 2.
module fast_irq_manager
    import fim_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [2:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               src0_edge,
    input  logic               norm_req,
    output logic [NUM_SRC-1:0] arb_vis,
    output logic               src0_clr,
    output logic               fiq_n,
    output logic               irq_n,
    output logic               int_n
);
    logic [NUM_SRC-1:0] redir;
    logic               set_stb;
    logic               clr_stb;
    logic               dbg_mask;
    logic               fast_act;

    fim_redirect_reg #(.NUM_SRC(NUM_SRC)) u_redir (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .wbits   (bus_wdata[NUM_SRC-1:0]),
        .redir   (redir)
    );

    fim_request #(.NUM_SRC(NUM_SRC)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (src_pend),
        .en       (src_en),
        .redir    (redir),
        .norm_req (norm_req),
        .dbg_mask (dbg_mask),
        .arb_vis  (arb_vis),
        .fast_act (fast_act),
        .fiq_n    (fiq_n),
        .irq_n    (irq_n),
        .int_n    (int_n)
    );

    fim_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .redir     (redir),
        .fast_act  (fast_act),
        .src0_edge (src0_edge),
        .fiq_n     (fiq_n),
        .irq_n     (irq_n),
        .set_stb   (set_stb),
        .clr_stb   (clr_stb),
        .dbg_mask  (dbg_mask),
        .rdata     (bus_rdata),
        .src0_clr  (src0_clr)
    );

    AST_ARB_HIDES_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_vis & redir) == '0); // R2

    AST_CLR_ONLY_UNREDIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
        src0_clr |-> (redir == '0)); // R6
endmodule

// File: tb/test_fast_irq_manager.sv
`timescale 1ns/1ps
module test_fast_irq_manager;
    localparam int N  = 12;
    localparam int DW = 32;
    localparam logic [31:0] VEC0 = 32'h1000_0100;
    localparam logic [31:0] SPUR = 32'h0BAD_0F00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  src_pend = '0, src_en = '0;
    logic          src0_edge = 1'b0, norm_req = 1'b0;
    logic [N-1:0]  arb_vis;
    logic          src0_clr, fiq_n, irq_n, int_n;

    always #2.5 clk = ~clk;

    fast_irq_manager #(.NUM_SRC(N), .DATA_W(DW)) i_fast_irq_manager (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pend(src_pend), .src_en(src_en), .src0_edge(src0_edge),
        .norm_req(norm_req), .arb_vis(arb_vis), .src0_clr(src0_clr),
        .fiq_n(fiq_n), .irq_n(irq_n), .int_n(int_n)
    );

    // Scoreboard queues: expected from the driver, actual from observation.
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] act_q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Monitor: pops matched pairs and compares.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            logic [31:0] e, g;
            string t;
            e = exp_q.pop_front(); g = act_q.pop_front(); t = tag_q.pop_front();
            n_cmp++;
            if (e !== g) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", t, g, e);
            end
        end
    end

    task automatic push(string t, logic [31:0] e, logic [31:0] g);
        tag_q.push_back(t); exp_q.push_back(e); act_q.push_back(g);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic check_read(string t, logic [2:0] a, logic [31:0] e,
                              logic exp_clr, bit chk_clr);
        logic [31:0] d; logic c;
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata; c = src0_clr;
        push(t, e, d);
        if (chk_clr) push({t, " clear pulse"}, {31'b0, exp_clr}, {31'b0, c});
        step();
        bus_rd = 1'b0;
    endtask

    task automatic check_lines(string t, logic f, logic i, logic c);
        #1 push(t, {29'b0, f, i, c}, {29'b0, fiq_n, irq_n, int_n});
    endtask

    task automatic apply(logic [N-1:0] p, logic [N-1:0] e, logic nr);
        src_pend = p; src_en = e; norm_req = nr;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        check_lines("R10 lines after reset", 1, 1, 1);
        check_read("R10 core status", 3'd0, 32'h0, 0, 0);
        check_read("R10 vec0", 3'd5, 32'h0, 0, 0);
        check_read("R10 debug", 3'd7, 32'h0, 0, 0);
        check_read("R1 redirect reset", 3'd3, 32'h0, 0, 0);

        wr(3'd5, VEC0);
        wr(3'd6, SPUR);
        // R1: write-one set/clear, bit 0 ignored
        wr(3'd1, 32'h00B);
        check_read("R1 set", 3'd3, 32'h00A, 0, 0);
        wr(3'd1, 32'h0);
        check_read("R1 set zero", 3'd3, 32'h00A, 0, 0);
        wr(3'd2, 32'h002);
        check_read("R1 clear", 3'd3, 32'h008, 0, 0);
        wr(3'd2, 32'h0);
        check_read("R1 clear zero", 3'd3, 32'h008, 0, 0);

        // R2: redirected and fast sources hidden from arbitration
        src_pend = '1; src_en = '1;
        #1 push("R2 visibility", 32'h0000_0FF6, {20'b0, arb_vis});
        step();

        // R3: redirected source 3 drives the fast line
        apply(12'h008, 12'h008, 0);
        check_lines("R3 redirected edge source", 0, 1, 0);
        // R4: vector of source 0 even for a redirected request; R6 no clear
        src0_edge = 1'b1;
        check_read("R4 fast vector via redirect", 3'd4, VEC0, 0, 1);
        // R3: unredirected normal source stays off the fast line
        apply(12'h004, 12'h004, 0);
        check_lines("R3 unredirected source", 1, 1, 1);
        // R5: spurious read
        check_read("R5 spurious", 3'd4, SPUR, 0, 1);
        apply(12'h001, 12'h000, 0);
        check_lines("R3 source 0 masked", 1, 1, 1);

        // R6: no redirect, edge source 0 -> clear pulse
        wr(3'd2, 32'hFFF);
        apply(12'h001, 12'h001, 0);
        check_lines("R3 source 0", 0, 1, 0);
        check_read("R6 edge read clears", 3'd4, VEC0, 1, 1);
        src0_edge = 1'b0;
        check_read("R6 level read no clear", 3'd4, VEC0, 0, 1);

        // R3: redirected level source drops
        wr(3'd1, 32'h020);
        apply(12'h020, 12'h020, 0);
        check_lines("R3 redirected level active", 0, 1, 0);
        apply(12'h000, 12'h020, 0);
        check_lines("R3 redirected level dropped", 1, 1, 1);

        // R7: debug mask
        wr(3'd7, 32'h1);
        check_read("R7 debug readback", 3'd7, 32'h1, 0, 0);
        apply(12'h001, 12'h001, 1);
        check_lines("R7 masked lines", 1, 1, 0);
        check_read("R9 core status masked", 3'd0, 32'h0, 0, 0);
        wr(3'd7, 32'h0);
        step();
        // R11 / R9
        check_lines("R11 both active", 0, 0, 0);
        check_read("R9 core status both", 3'd0, 32'h3, 0, 0);
        apply(12'h000, 12'h000, 1);
        check_lines("R11 normal only", 1, 0, 0);
        check_read("R9 core status normal", 3'd0, 32'h2, 0, 0);
        // R8: idle combined line
        apply(12'h000, 12'h000, 0);
        check_lines("R8 idle", 1, 1, 1);

        repeat (3) step();
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule